// File: doc/BRIEF.md
# SAR ADC conversion controller

This block runs the digital side of a 14-bit successive-approximation converter. An external capacitive DAC and comparator do the analog work. While idle, the controller holds the converter in its acquire phase: the sample switches stay closed and the comparator offset is being zeroed. It also times how long that phase has lasted. A conversion is requested when the select and start inputs are both high. The request is accepted only after the minimum acquire window has passed. A request that arrives too early is remembered and served as soon as the window is met.

Once a conversion is accepted, both analog controls are released and the SAR register is cleared. The controller then offers the DAC one trial code per clock, working from bit 13 down to bit 0. It reads back one comparator decision in each of those clocks. After the last decision, the complete word is copied into the output latch in one step, and a one-cycle valid pulse marks the new word. Start requests made while a conversion runs are dropped.

The result is a pulse-qualified word with no ready input. A consumer cannot stall it and must capture the word during the valid cycle or later. The word is held until the next conversion completes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_o and result_vld_o are 0, sample_o and zero_o are 1, and result_o is 0.
- R2: A start request is sel_i and start_i both high in the same cycle. Either input high on its own starts nothing.
- R3: A conversion begins only after sample_o has been high for at least ACQ_CYC cycles. A request made earlier in the acquire phase is held and starts the conversion at the first edge where the window is met, so busy_o rises exactly ACQ_CYC cycles after acquire began.
- R4: sample_o and zero_o are high in every acquire cycle and low in every conversion cycle.
- R5: trial_o walks from the MSB to the LSB. In the k-th conversion cycle (k = 0..13), bit 13-k is 1, the bits above it hold earlier decisions, and the bits below it are 0.
- R6: The SAR register is cleared when a conversion starts, so the first trial code is always 14'h2000 whatever the previous result was.
- R7: A trial bit stays 1 when cmp_i is 1 in its cycle (DAC below input) and becomes 0 otherwise. With an ideal comparator, result_o equals the input code.
- R8: busy_o is high for exactly 14 cycles per conversion. It falls in the cycle in which result_o is loaded, and result_vld_o is high for exactly that one cycle.
- R9: result_o keeps its value between loads, regardless of input activity.
- R10: Start requests made during a conversion, including in the final bit cycle, neither disturb it nor cause a later conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Select; qualifies start_i |
| start_i | input | 1 | Convert-start request |
| cmp_i | input | 1 | Comparator decision, 1 = DAC below input |
| sample_o | output | 1 | Sample switches closed |
| zero_o | output | 1 | Comparator zeroing active |
| trial_o | output | 14 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 14 | Output latch |
| result_vld_o | output | 1 | One-cycle pulse on each latch load |

## Verification
Two pairs of events can land in the same cycle. The first pair is a start request and the final bit decision with its latch load. The bench raises select and start in the LSB cycle and also in a middle bit. It then requires the correct word, busy low from the load onward, and no new conversion over a full acquire window. The second pair is a pending or fresh request and expiry of the acquire window. The bench raises a request right after a conversion, and also in the last cycle before the window closes. In both cases busy must rise exactly ACQ_CYC cycles after the previous load.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic {
    PH_ACQ  = 1'b0,
    PH_CONV = 1'b1
  } phase_e;
endpackage

// File: rtl/sar_acq_timer.sv
// Counts acquire cycles and saturates once the minimum window is reached.
module sar_acq_timer #(
  parameter int ACQ_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(ACQ_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ACQ_CYC - 1);

  logic [CW-1:0] cnt;

  // done means the current cycle completes the window
  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
// SAR register plus a one-hot probe marking the bit under trial.
module sar_bit_engine #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] trial,
  output logic [W-1:0] word_nxt,
  output logic         last
);
  logic [W-1:0] sar_q;
  logic [W-1:0] probe_q;

  assign trial = sar_q | probe_q;
  assign last  = probe_q[0];

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign word_nxt[b] = sar_q[b] | (probe_q[b] & cmp);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sar_q[b]   <= 1'b0;
        probe_q[b] <= 1'b0;
      end else if (clear) begin
        sar_q[b]   <= 1'b0;
        probe_q[b] <= (b == W - 1);
      end else if (step) begin
        sar_q[b]   <= word_nxt[b];
        probe_q[b] <= (b == W - 1) ? 1'b0 : probe_q[(b + 1) % W];
      end
    end
  end
endmodule

// File: rtl/sar_out_latch.sv
// Holds the finished word; flags each load for one cycle.
module sar_out_latch #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int W       = 14,
  parameter int ACQ_CYC = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic         sample_o,
  output logic         zero_o,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic [W-1:0] result_o,
  output logic         result_vld_o
);
  phase_e       phase_q;
  logic         pend_q;
  logic         req, in_acq, acq_done, go, fin, last;
  logic [W-1:0] word_nxt;

  assign req    = sel_i && start_i;
  assign in_acq = (phase_q == PH_ACQ);
  assign go     = in_acq && acq_done && (req || pend_q);
  assign fin    = (phase_q == PH_CONV) && last;

  sar_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_acq),
    .done (acq_done)
  );

  sar_bit_engine #(.W(W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (go),
    .step    (phase_q == PH_CONV),
    .cmp     (cmp_i),
    .trial   (trial_o),
    .word_nxt(word_nxt),
    .last    (last)
  );

  sar_out_latch #(.W(W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fin),
    .d    (word_nxt),
    .q    (result_o),
    .vld  (result_vld_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      pend_q  <= 1'b0;
    end else begin
      if (go) phase_q <= PH_CONV;
      else if (fin) phase_q <= PH_ACQ;
      // requests are only remembered while acquiring
      if (go) pend_q <= 1'b0;
      else if (in_acq && req) pend_q <= 1'b1;
    end
  end

  assign busy_o   = (phase_q == PH_CONV);
  assign sample_o = in_acq;
  assign zero_o   = in_acq;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W       = 14,
  parameter int ACQ_CYC = 100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sample_o,
  input logic         zero_o,
  input logic [W-1:0] trial_o,
  input logic         busy_o,
  input logic [W-1:0] result_o,
  input logic         result_vld_o
);
  localparam int BW = $clog2(W + 1) + 1;
  localparam int AW = $clog2(ACQ_CYC + 1) + 1;

  logic [BW-1:0] busy_run;
  logic [AW-1:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
      idle_run <= '0;
    end else begin
      busy_run <= busy_o ? busy_run + 1'b1 : '0;
      if (busy_o) idle_run <= '0;
      else if (idle_run < AW'(ACQ_CYC)) idle_run <= idle_run + 1'b1;
    end
  end

  a_r4_released_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!sample_o && !zero_o));
  a_r4_closed_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sample_o && zero_o));
  a_r3_acq_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (idle_run >= AW'(ACQ_CYC)));
  a_r6_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (trial_o == {1'b1, {(W-1){1'b0}}}));
  a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_run < BW'(W)));
  a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == BW'(W)));
  a_r8_vld_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> result_vld_o);
  a_r8_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld_o |-> $stable(result_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W), .ACQ_CYC(ACQ_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_o    (sample_o),
  .zero_o      (zero_o),
  .trial_o     (trial_o),
  .busy_o      (busy_o),
  .result_o    (result_o),
  .result_vld_o(result_vld_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int W   = 14;
  localparam int ACQ = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, start = 1'b0;
  logic cmp;
  logic sample, zero, busy, vld;
  logic [W-1:0] trial, result;
  logic [W-1:0] vin = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign cmp = (trial <= vin);  // ideal comparator

  sar_conv_ctrl #(.W(W), .ACQ_CYC(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start), .cmp_i(cmp),
    .sample_o(sample), .zero_o(zero), .trial_o(trial), .busy_o(busy),
    .result_o(result), .result_vld_o(vld)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_req();
    sel = 1'b1; start = 1'b1;
    @(negedge clk);
    sel = 1'b0; start = 1'b0;
  endtask

  task automatic wait_acq();
    repeat (ACQ + 2) @(negedge clk);
  endtask

  // Request issued now (window already met); returns at the negedge after the load.
  task automatic run_conv(input logic [W-1:0] v, input bit inject);
    logic [W-1:0] acc;
    logic [W-1:0] exp;
    vin = v;
    pulse_req();
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    acc = '0;
    for (int j = W - 1; j >= 0; j--) begin
      exp = acc | (W'(1) << j);
      chk(trial == exp, "R5 R6 trial code", trial, exp);
      chk(!sample && !zero, "R4 released", {sample, zero}, 0);
      chk(busy && !vld, "R8 busy during bits", {busy, vld}, 2);
      if (v[j]) acc[j] = 1'b1;
      if (inject && (j == 7 || j == 0)) begin sel = 1'b1; start = 1'b1; end
      @(negedge clk);
      sel = 1'b0; start = 1'b0;
    end
    chk(!busy && vld, "R8 busy fall with valid", {busy, vld}, 1);
    chk(result == v, "R7 result word", result, v);
    chk(sample && zero, "R4 back to acquire", {sample, zero}, 3);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3 * W && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !vld, "R1 busy/valid", {busy, vld}, 0);
    chk(sample && zero, "R1 acquire controls", {sample, zero}, 3);
    chk(result == '0, "R1 result", result, 0);
  endtask

  task automatic t_gating();
    logic [W-1:0] keep;
    wait_acq();
    keep = result;
    sel = 1'b1; start = 1'b0;
    repeat (4) begin @(negedge clk); chk(!busy, "R2 select alone", busy, 0); end
    sel = 1'b0; start = 1'b1;
    repeat (4) begin @(negedge clk); chk(!busy, "R2 start alone", busy, 0); end
    start = 1'b0;
    @(negedge clk);
    chk(result == keep && !vld, "R2 R9 no load", result, keep);
  endtask

  task automatic t_values();
    logic [W-1:0] pat [5] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555, 14'h2001};
    foreach (pat[i]) begin
      wait_acq();
      run_conv(pat[i], 1'b0);
      @(negedge clk);
      chk(!vld, "R8 valid one cycle", vld, 0);
      chk(result == pat[i], "R9 held after load", result, pat[i]);
    end
  endtask

  task automatic t_pending();
    wait_acq();
    run_conv(14'h0F0F, 1'b0);
    pulse_req();  // early request, must be held
    for (int k = 2; k <= ACQ; k++) begin
      @(negedge clk);
      if (k < ACQ) begin
        if (busy) chk(1'b0, "R3 started early", k, ACQ);
      end else chk(busy, "R3 pending served at window end", busy, 1);
    end
    wait_idle();
    chk(result == 14'h0F0F, "R7 pending conversion", result, 14'h0F0F);
    // request arriving in the very cycle the window completes
    repeat (ACQ - 1) @(negedge clk);
    vin = 14'h3210;
    pulse_req();
    chk(busy, "R3 request at expiry", busy, 1);
    wait_idle();
    chk(result == 14'h3210, "R7 expiry conversion", result, 14'h3210);
  endtask

  task automatic t_restart();
    wait_acq();
    run_conv(14'h1234, 1'b1);
    chk(result == 14'h1234, "R10 word undisturbed", result, 14'h1234);
    for (int k = 0; k < ACQ + 5; k++) begin
      @(negedge clk);
      if (busy) chk(1'b0, "R10 restart leaked", busy, 0);
    end
    chk(!busy && result == 14'h1234, "R10 R9 stays idle", result, 14'h1234);
  endtask

  task automatic t_hold();
    vin = 14'h0001;
    repeat (20) @(negedge clk);
    chk(result == 14'h1234 && !vld, "R9 hold under input change", result, 14'h1234);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_values();
    t_pending();
    t_restart();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule